// File: doc/BRIEF.md
# ROM Patch Address Redirect Unit

This block sits next to a processor's instruction fetch path and lets firmware fix up to two faulty locations in mask ROM. Software programs a 16-bit opcode address into each of two patch slots and sets the enable bit for each slot it wants active. All of this goes through a byte-wide register bus. When the processor fetches the opcode byte of an instruction whose address equals an enabled slot's address, the block raises a redirect request. The request carries the start of that slot's fixed 32-byte patch window in RAM, and the processor continues from there.

The two patch windows are adjacent in RAM. Slot one's window is 0x02C0 to 0x02DF and slot two's is 0x02E0 to 0x02FF. Patch code may therefore run from the first window straight into the second. Fetches that fall anywhere in the combined window are never compared, so patch code can neither retrigger itself nor be interrupted as it crosses from one window into the next. A patch normally ends with a 3-byte absolute jump back into ROM.

Top module: `rom_patch_redirect`

## Requirements
- R1: After reset both match addresses read back as 0x0000, the enable register reads 0x00, and no redirect is raised for any fetch.
- R2: Bytes are laid out as slot one high/low at 0x0242/0x0243 and slot two high/low at 0x0244/0x0245. A write updates only the addressed byte, takes effect at the next clock edge and reads back unchanged.
- R3: The enable register is at 0x0246. Bit 0 enables slot one and bit 1 enables slot two. Bits 3:2 are stored and read back. Bits 7:4 ignore writes and always read 0.
- R4: An opcode fetch outside the patch window that matches slot one, with slot one enabled, raises redirectValid in the same cycle with redirectAddr = 0x02C0.
- R5: An opcode fetch outside the patch window that matches slot two, with slot two enabled, raises redirectValid in the same cycle with redirectAddr = 0x02E0.
- R6: A slot whose enable bit is 0 never causes a redirect, even when its address matches.
- R7: With opcodeFetch low (an operand or data fetch), redirectValid stays low whatever the address.
- R8: A fetch whose address lies in 0x02C0 to 0x02FF never raises a redirect, so consecutive fetches across 0x02DF to 0x02E0 pass untouched.
- R9: If both enabled slots match the same fetch, slot one wins and redirectAddr = 0x02C0.
- R10: While redirectValid is low, redirectAddr is 0x0000.
- R11: Register addresses other than 0x0242 to 0x0246 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 16 | Register bus byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| opcodeFetch | input | 1 | High when fetchAddr is the opcode byte of an instruction |
| fetchAddr | input | 16 | Current fetch address |
| redirectValid | output | 1 | Redirect request, same cycle as the fetch |
| redirectAddr | output | 16 | Patch window start address, 0 when idle |

## Verification
The bench sweeps the whole low 4 KB address range under each of the four enable combinations, with the opcode strobe both high and low. One slot's match address is deliberately placed inside the patch window. A design that compared window fetches would redirect patch code back into itself, and one that ignored the strobe would fire on operand bytes; the sweep catches both. A second configuration loads the same address into both slots to check that slot one wins, since a reversed priority would send the processor to 0x02E0. Byte-level writes are read back in both orders, along with writes to unmapped and upper-enable bits, to catch a write that corrupts the neighbouring byte or stores bits that must read zero.

// File: rtl/patch_pkg.sv
package patch_pkg;
  localparam int unsigned NUM_SLOTS = 2;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] wrHi;
    logic [NUM_SLOTS-1:0] wrLo;
    logic                 wrEnable;
    logic [NUM_SLOTS-1:0] rdHi;
    logic [NUM_SLOTS-1:0] rdLo;
    logic                 rdEnable;
  } patchStrobes_t;
endpackage

// File: rtl/patch_ctrl.sv
module patch_ctrl
  import patch_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned REG_BASE = 'h0242
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output patchStrobes_t     strobes
);
  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(REG_BASE + 2 * NUM_SLOTS);

  logic [NUM_SLOTS-1:0] hiSel;
  logic [NUM_SLOTS-1:0] loSel;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(REG_BASE + 2 * s);
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(REG_BASE + 2 * s + 1);
    assign hiSel[s] = (regAddr == HI_ADDR);
    assign loSel[s] = (regAddr == LO_ADDR);
  end

  always_comb begin
    strobes.rdHi     = hiSel;
    strobes.rdLo     = loSel;
    strobes.rdEnable = (regAddr == EN_ADDR);
    strobes.wrHi     = regWrEn ? hiSel : '0;
    strobes.wrLo     = regWrEn ? loSel : '0;
    strobes.wrEnable = regWrEn && (regAddr == EN_ADDR);
  end
endmodule

// File: rtl/patch_datapath.sv
module patch_datapath
  import patch_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned EN_BITS   = 4,
  parameter int unsigned WIN_BASE  = 'h02C0,
  parameter int unsigned WIN_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  patchStrobes_t     strobes,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              opcodeFetch,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectAddr
);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(WIN_BASE + NUM_SLOTS * WIN_BYTES - 1);

  logic [ADDR_W-1:0]    matchReg [NUM_SLOTS];
  logic [EN_BITS-1:0]   enableReg;
  logic [NUM_SLOTS-1:0] hitVec;
  logic                 inWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) matchReg[s] <= '0;
      enableReg <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (strobes.wrHi[s]) matchReg[s][ADDR_W-1:DATA_W] <= regWrData;
        if (strobes.wrLo[s]) matchReg[s][DATA_W-1:0]      <= regWrData;
      end
      if (strobes.wrEnable) enableReg <= regWrData[EN_BITS-1:0];
    end
  end

  always_comb begin
    regRdData = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (strobes.rdHi[s]) regRdData = matchReg[s][ADDR_W-1:DATA_W];
      if (strobes.rdLo[s]) regRdData = matchReg[s][DATA_W-1:0];
    end
    if (strobes.rdEnable) regRdData = DATA_W'(enableReg);
  end

  assign inWindow = (fetchAddr >= WIN_LO) && (fetchAddr <= WIN_HI);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    assign hitVec[s] = opcodeFetch && !inWindow && enableReg[s] &&
                       (fetchAddr == matchReg[s]);
  end

  always_comb begin
    redirectValid = |hitVec;
    redirectAddr  = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (hitVec[s]) redirectAddr = ADDR_W'(WIN_BASE + s * WIN_BYTES);
    end
  end
endmodule

// File: rtl/rom_patch_redirect.sv
module rom_patch_redirect
  import patch_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned EN_BITS   = 4,
  parameter int unsigned REG_BASE  = 'h0242,
  parameter int unsigned WIN_BASE  = 'h02C0,
  parameter int unsigned WIN_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              opcodeFetch,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              redirectValid,
  output logic [ADDR_W-1:0] redirectAddr
);
  patchStrobes_t strobes;

  patch_ctrl #(.ADDR_W(ADDR_W), .REG_BASE(REG_BASE)) ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes)
  );

  patch_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_BITS(EN_BITS),
    .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
  ) dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .regWrData     (regWrData),
    .regRdData     (regRdData),
    .opcodeFetch   (opcodeFetch),
    .fetchAddr     (fetchAddr),
    .redirectValid (redirectValid),
    .redirectAddr  (redirectAddr)
  );
endmodule

// File: rtl/rom_patch_redirect_chk.sv
module rom_patch_redirect_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] regAddr,
  input logic        regWrEn,
  input logic [7:0]  regWrData,
  input logic [7:0]  regRdData,
  input logic        opcodeFetch,
  input logic [15:0] fetchAddr,
  input logic        redirectValid,
  input logic [15:0] redirectAddr
);
  AST_OPCODE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> opcodeFetch); // R7
  AST_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (fetchAddr >= 16'h02C0 && fetchAddr <= 16'h02FF) |-> !redirectValid); // R8
  AST_TARGET_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (redirectAddr == 16'h02C0 || redirectAddr == 16'h02E0)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !redirectValid |-> redirectAddr == 16'h0000); // R10
  AST_UPPER_EN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 16'h0246) |-> regRdData[7:4] == 4'h0); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr < 16'h0242 || regAddr > 16'h0246) |-> regRdData == 8'h00); // R11
  AST_FIRST_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !redirectValid); // R1
endmodule

bind rom_patch_redirect rom_patch_redirect_chk chk (.*);

// File: tb/rom_patch_redirect_test.sv
`timescale 1ns/1ps
module rom_patch_redirect_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        opcodeFetch = 1'b0;
  logic [15:0] fetchAddr = '0;
  logic        redirectValid;
  logic [15:0] redirectAddr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  rom_patch_redirect uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic regWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, {24'b0, regRdData}, {24'b0, exp});
  endtask

  task automatic sweep(input logic [15:0] m1, input logic [15:0] m2, input logic [1:0] en);
    for (int st = 0; st < 2; st++) begin
      for (int a = 0; a < 4096; a++) begin
        logic inWin, h1, h2, v;
        logic [15:0] ea;
        string tag;
        fetchAddr = 16'(a);
        opcodeFetch = st[0];
        #1;
        inWin = (a >= 'h02C0) && (a <= 'h02FF);
        h1 = en[0] && (16'(a) == m1);
        h2 = en[1] && (16'(a) == m2);
        v  = st[0] && !inWin && (h1 || h2);
        ea = !v ? 16'h0000 : (h1 ? 16'h02C0 : 16'h02E0);
        if (st == 0) tag = "R7";
        else if (inWin) tag = "R8";
        else if (h1 && h2) tag = "R9";
        else if (h1) tag = "R4";
        else if (h2) tag = "R5";
        else if (16'(a) == m1 || 16'(a) == m2) tag = "R6";
        else tag = "R10";
        check(tag, {15'b0, redirectValid, redirectAddr}, {15'b0, v, ea});
      end
    end
    opcodeFetch = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    regRead("R1", 16'h0242, 8'h00);
    regRead("R1", 16'h0243, 8'h00);
    regRead("R1", 16'h0244, 8'h00);
    regRead("R1", 16'h0245, 8'h00);
    regRead("R1", 16'h0246, 8'h00);
    fetchAddr = 16'h0000; opcodeFetch = 1'b1; #1;
    check("R1", {31'b0, redirectValid}, 32'd0);
    opcodeFetch = 1'b0;

    // R2 byte-wise writes
    regWrite(16'h0242, 8'hA5);
    regRead("R2", 16'h0242, 8'hA5);
    regRead("R2", 16'h0243, 8'h00);
    regWrite(16'h0245, 8'h3C);
    regRead("R2", 16'h0245, 8'h3C);
    regRead("R2", 16'h0244, 8'h00);
    regRead("R2", 16'h0242, 8'hA5);
    regWrite(16'h0243, 8'h5A);
    regRead("R2", 16'h0242, 8'hA5);
    regRead("R2", 16'h0243, 8'h5A);

    // R3 enable register bits
    regWrite(16'h0246, 8'hFF);
    regRead("R3", 16'h0246, 8'h0F);
    regWrite(16'h0246, 8'hA6);
    regRead("R3", 16'h0246, 8'h06);
    regWrite(16'h0246, 8'h00);

    // R11 unmapped addresses
    regWrite(16'h0247, 8'hAA);
    regWrite(16'h0241, 8'h55);
    regRead("R11", 16'h0247, 8'h00);
    regRead("R11", 16'h0241, 8'h00);
    regRead("R11", 16'h0242, 8'hA5);
    regRead("R11", 16'h0245, 8'h3C);
    regRead("R11", 16'h0246, 8'h00);

    // Distinct slots, slot two placed inside the patch window
    regWrite(16'h0242, 8'h03); regWrite(16'h0243, 8'h45);
    regWrite(16'h0244, 8'h02); regWrite(16'h0245, 8'hE3);
    for (int e = 0; e < 4; e++) begin
      regWrite(16'h0246, 8'(e));
      sweep(16'h0345, 16'h02E3, 2'(e));
    end
    // Slot two outside the window
    regWrite(16'h0244, 8'h0A); regWrite(16'h0245, 8'hBC);
    for (int e = 0; e < 4; e++) begin
      regWrite(16'h0246, 8'(e));
      sweep(16'h0345, 16'h0ABC, 2'(e));
    end
    // Both slots equal: priority
    regWrite(16'h0244, 8'h03); regWrite(16'h0245, 8'h45);
    regWrite(16'h0246, 8'h03);
    sweep(16'h0345, 16'h0345, 2'b11);

    // Chained windows crossing 0x02DF -> 0x02E0 (R8)
    regWrite(16'h0242, 8'h02); regWrite(16'h0243, 8'hDF);
    regWrite(16'h0244, 8'h02); regWrite(16'h0245, 8'hE0);
    opcodeFetch = 1'b1;
    fetchAddr = 16'h02DF; #1;
    check("R8", {15'b0, redirectValid, redirectAddr}, 32'd0);
    fetchAddr = 16'h02E0; #1;
    check("R8", {15'b0, redirectValid, redirectAddr}, 32'd0);
    opcodeFetch = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule